// File: doc/BRIEF.md
# Serial Port Register and Interrupt Unit

This block is the register front end of a fast 8N1 serial port. A simple 32-bit bus reaches five word registers: a data port, a fill-level report, a status register, a control word and a rate divisor. Writing the data port queues one byte for the transmitter. Reading it removes one received character, together with that character's framing-error and break flags. If nothing has been received, the read returns an "empty" marker and removes nothing.

The transmit and receive shift engines are outside this block. They appear here as stimulus ports. The transmitter takes bytes with `tx_pop`. The receiver delivers characters with `rx_push`. Both sides buffer up to `DEPTH` entries (64 by default).

Two kinds of event drive the single interrupt line:
- **Latched events:** transmit request, framing error, break and overrun. Each stays set until software writes 1 to its bit.
- **Live conditions:** receive trigger and receive timeout. These follow the receive buffer state.

Three enable bits in the control word gate these sources onto the interrupt line.

Top module: `hsio_csr`

## Requirements
- R1: After reset the following hold:
  - level, status and control read 0;
  - rate reads 0xFF;
  - `irq`, `line_break` and `tx_avail` are 0.
- R2: A data-port write (word offset 0x00) queues `bus_wdata[7:0]`. `tx_byte` shows the oldest queued byte and `tx_avail` is high while anything is queued. Each `tx_pop` removes the oldest byte, so bytes leave in write order.
- R3: A data-port write while the transmit buffer holds `DEPTH` entries is ignored. The count stays at `DEPTH` and the queued bytes are unchanged.
- R4: A data-port read returns a word that depends on the receive buffer:
  - with a character waiting, the oldest character is in bits 7:0, its framing-error flag is in bit 9 and its break flag is in bit 10;
  - with the buffer empty, the word is 0x100 (bit 8 set) and nothing is removed.
- R5: The level register (offset 0x04) holds the transmit count in bits 15:8 and the receive count in bits 7:0.
- R6: A receive push while the receive buffer is full drops the character and sets status bit 5 (overrun).
- R7: Status bits 3 (framing) and 4 (break) set when a character carrying that flag is accepted. Status bits 0, 3, 4 and 5 clear only when 1 is written to them at offset 0x08. Writing status bits 1 and 2 has no effect.
- R8: Control bits 1:0 select a transmit low mark of 0, 4, 8 or 16 (encodings 0 to 3). Status bit 0 sets when a `tx_pop` leaves the transmit count at or below that mark.
- R9: Control bits 4:2 select a receive trigger level of 1, 4, 8, 16, 32 or 48 (encodings 0 to 5; encodings 6 and 7 mean 48). Status bit 1 reads 1 exactly while the receive count is at or above that level.
- R10: Status bit 2 reads 1 once the receive buffer has been non-empty for `TMO` cycles with no push and no pop. Any push or pop restarts that count.
- R11: `irq` is the OR of three gated terms:
  - control bit 5 AND status bit 0;
  - control bit 6 AND (status bit 1 OR status bit 2);
  - control bit 7 AND (status bit 3, 4 or 5).

  Status bit 6 reads as status bit 0 AND control bit 5.
- R12: Control bit 8 drives `line_break`. The rate register (offset 0x10, bits 7:0) is read/write and drives `rate_div`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address; word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| tx_pop | input | 1 | Transmitter takes the oldest byte |
| tx_byte | output | 8 | Oldest queued transmit byte |
| tx_avail | output | 1 | Transmit buffer non-empty |
| rx_push | input | 1 | Receiver delivers a character |
| rx_char | input | 8 | Received character |
| rx_ferr | input | 1 | Character had a framing error |
| rx_brk | input | 1 | Character was a break |
| line_break | output | 1 | Force break on the line |
| rate_div | output | 8 | Baud divisor value |
| irq | output | 1 | Interrupt request |

## Verification
The bench fills both buffers past `DEPTH` and checks the following failure modes:
- An off-by-one limit would accept a 65th byte or replace a queued character instead of dropping the new one.
- A read of the empty receive buffer must still return 0x100 and leave the count at zero; a design that popped anyway would corrupt the count.
- Writes of 1 to the live status bits must not clear them while their condition holds; a design that treated them as latches would lose a pending timeout.
- A design that tested the low mark before the pop instead of after it would raise the transmit request one byte late.
- A design that counted pushes but not pops as activity would fire the receive timeout early.

Random interleavings of queueing, draining, pushing and reading are compared against queue models.

// File: rtl/hsio_pkg.sv
package hsio_pkg;

  typedef enum logic [2:0] {
    REG_DATA  = 3'd0,
    REG_LEVEL = 3'd1,
    REG_STAT  = 3'd2,
    REG_CTRL  = 3'd3,
    REG_RATE  = 3'd4
  } reg_idx_e;

  localparam int CT_TXEN  = 5;
  localparam int CT_RXEN  = 6;
  localparam int CT_ERREN = 7;
  localparam int CT_BRK   = 8;

  // Receive trigger level from control bits 4:2
  function automatic int rx_trig_level(logic [2:0] sel);
    case (sel)
      3'd0:    return 1;
      3'd1:    return 4;
      3'd2:    return 8;
      3'd3:    return 16;
      3'd4:    return 32;
      default: return 48;
    endcase
  endfunction

  // Transmit low mark from control bits 1:0
  function automatic int tx_low_mark(logic [1:0] sel);
    case (sel)
      2'd0:    return 0;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 16;
    endcase
  endfunction

  function automatic logic [31:0] level_word(int txc, int rxc);
    return {16'h0, 8'(txc), 8'(rxc)};
  endfunction

  function automatic logic [31:0] rx_word(logic [9:0] entry, logic empty);
    if (empty) return 32'h0000_0100;
    return {21'h0, entry[9], entry[8], 1'b0, entry[7:0]};
  endfunction

endpackage

// File: rtl/hsio_fifo.sv
module hsio_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];
  assign count   = cnt;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/hsio_irq.sv
module hsio_irq #(
  parameter int TMO = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_txreq,
  input  logic       set_fe,
  input  logic       set_brk,
  input  logic       set_ovr,
  input  logic       clr_wr,
  input  logic [3:0] clr_bits,   // {ovr, brk, fe, txreq}
  input  logic       trig_live,
  input  logic       rx_nonempty,
  input  logic       rx_act,
  input  logic       en_tx,
  input  logic       en_rx,
  input  logic       en_err,
  output logic [6:0] status,
  output logic       irq
);
  localparam int TW = $clog2(TMO + 1);

  logic          l_tx, l_fe, l_brk, l_ovr;
  logic [TW-1:0] idle;
  logic          tmo_live;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_tx <= 1'b0; l_fe <= 1'b0; l_brk <= 1'b0; l_ovr <= 1'b0;
    end else begin
      l_tx  <= set_txreq | (l_tx  & ~(clr_wr & clr_bits[0]));
      l_fe  <= set_fe    | (l_fe  & ~(clr_wr & clr_bits[1]));
      l_brk <= set_brk   | (l_brk & ~(clr_wr & clr_bits[2]));
      l_ovr <= set_ovr   | (l_ovr & ~(clr_wr & clr_bits[3]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !rx_nonempty || rx_act) idle <= '0;
    else if (idle != TW'(TMO))            idle <= idle + TW'(1);
  end

  assign tmo_live = (idle == TW'(TMO));
  assign status   = {l_tx & en_tx, l_ovr, l_brk, l_fe, tmo_live, trig_live, l_tx};
  assign irq      = (en_tx & l_tx) | (en_rx & (trig_live | tmo_live))
                  | (en_err & (l_fe | l_brk | l_ovr));
endmodule

// File: rtl/hsio_csr.sv
module hsio_csr
  import hsio_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int TMO   = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        tx_pop,
  output logic [7:0]  tx_byte,
  output logic        tx_avail,
  input  logic        rx_push,
  input  logic [7:0]  rx_char,
  input  logic        rx_ferr,
  input  logic        rx_brk,
  output logic        line_break,
  output logic [7:0]  rate_div,
  output logic        irq
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [31:0]   ctrl_q;
  logic [7:0]    rate_q;
  logic [2:0]    idx;
  logic          hit, wr_hit, rd_hit;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic [9:0]    rx_head;
  logic [6:0]    status;

  // Named internal events, used by the checker
  logic tx_push_do, tx_pop_do, rx_push_do, rx_pop_req, rx_pop_do, ovr_ev, txreq_ev;

  assign hit    = bus_sel && (bus_addr[1:0] == 2'b00);
  assign idx    = bus_addr[4:2];
  assign wr_hit = hit && bus_wr;
  assign rd_hit = hit && !bus_wr;

  assign tx_push_do = wr_hit && (idx == REG_DATA) && !tx_full;
  assign tx_pop_do  = tx_pop && !tx_empty;
  assign rx_push_do = rx_push && !rx_full;
  assign ovr_ev     = rx_push && rx_full;
  assign rx_pop_req = rd_hit && (idx == REG_DATA);
  assign rx_pop_do  = rx_pop_req && !rx_empty;
  assign txreq_ev   = tx_pop_do && ((int'(tx_cnt) - 1) <= tx_low_mark(ctrl_q[1:0]));

  hsio_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push_do), .din(bus_wdata[7:0]),
    .pop(tx_pop_do), .dout(tx_byte), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  hsio_fifo #(.W(10), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push_do), .din({rx_brk, rx_ferr, rx_char}),
    .pop(rx_pop_do), .dout(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  hsio_irq #(.TMO(TMO)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .set_txreq(txreq_ev),
    .set_fe(rx_push_do && rx_ferr),
    .set_brk(rx_push_do && rx_brk),
    .set_ovr(ovr_ev),
    .clr_wr(wr_hit && (idx == REG_STAT)),
    .clr_bits({bus_wdata[5], bus_wdata[4], bus_wdata[3], bus_wdata[0]}),
    .trig_live(int'(rx_cnt) >= rx_trig_level(ctrl_q[4:2])),
    .rx_nonempty(!rx_empty),
    .rx_act(rx_push_do || rx_pop_do),
    .en_tx(ctrl_q[CT_TXEN]), .en_rx(ctrl_q[CT_RXEN]), .en_err(ctrl_q[CT_ERREN]),
    .status(status), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rate_q <= 8'hFF;
    end else if (wr_hit) begin
      if (idx == REG_CTRL) ctrl_q <= bus_wdata;
      if (idx == REG_RATE) rate_q <= bus_wdata[7:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_hit) begin
      case (idx)
        REG_DATA:  bus_rdata = rx_word(rx_head, rx_empty);
        REG_LEVEL: bus_rdata = level_word(int'(tx_cnt), int'(rx_cnt));
        REG_STAT:  bus_rdata = {25'h0, status};
        REG_CTRL:  bus_rdata = ctrl_q;
        REG_RATE:  bus_rdata = {24'h0, rate_q};
        default:   bus_rdata = '0;
      endcase
    end
  end

  assign tx_avail   = !tx_empty;
  assign line_break = ctrl_q[CT_BRK];
  assign rate_div   = rate_q;
endmodule

// File: rtl/hsio_csr_chk.sv
module hsio_csr_chk #(
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [4:0]    bus_addr,
  input logic [31:0]   bus_wdata,
  input logic          rx_push,
  input logic          irq,
  input logic [7:0]    rate_div,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic          tx_push_do,
  input logic          tx_pop_do,
  input logic          rx_pop_req,
  input logic [31:0]   ctrl_q,
  input logic [6:0]    status
);
  // R2
  tx_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push_do |=> tx_cnt == $past(tx_cnt) + CW'(1) - CW'($past(tx_pop_do)));

  // R3
  tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH));

  // R4
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop_req && rx_cnt == '0 && !rx_push) |=> rx_cnt == '0);

  // R6
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_cnt == CW'(DEPTH)) |=> status[5]);

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[7:5] == 3'b000) |-> !irq);

  // R12
  rate_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 5'h10) |=> rate_div == $past(bus_wdata[7:0]));
endmodule

bind hsio_csr hsio_csr_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .rx_push(rx_push), .irq(irq), .rate_div(rate_div),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .tx_push_do(tx_push_do), .tx_pop_do(tx_pop_do),
  .rx_pop_req(rx_pop_req), .ctrl_q(ctrl_q), .status(status)
);

// File: tb/tb_hsio_csr.sv
module tb_hsio_csr;
  localparam int DEPTH = 64;
  localparam int TMO   = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_pop = 1'b0;
  logic [7:0]  tx_byte;
  logic        tx_avail;
  logic        rx_push = 1'b0;
  logic [7:0]  rx_char = '0;
  logic        rx_ferr = 1'b0, rx_brk = 1'b0;
  logic        line_break;
  logic [7:0]  rate_div;
  logic        irq;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  hsio_csr #(.DEPTH(DEPTH), .TMO(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_pop(tx_pop), .tx_byte(tx_byte),
    .tx_avail(tx_avail), .rx_push(rx_push), .rx_char(rx_char), .rx_ferr(rx_ferr),
    .rx_brk(rx_brk), .line_break(line_break), .rate_div(rate_div), .irq(irq)
  );

  localparam logic [4:0] A_DATA = 5'h00, A_LVL = 5'h04, A_STAT = 5'h08,
                         A_CTRL = 5'h0C, A_RATE = 5'h10;

  function automatic logic [31:0] exp_rx(logic [7:0] c, logic fe, logic bk);
    return {21'h0, bk, fe, 1'b0, c};
  endfunction

  function automatic logic [31:0] exp_lvl(int t, int r);
    return (32'(t) << 8) | 32'(r);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge
  task automatic wr(logic [4:0] a, logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic txp(output logic [7:0] b);
    b = tx_byte;
    tx_pop = 1'b1;
    @(negedge clk);
    tx_pop = 1'b0;
  endtask

  task automatic rxp(logic [7:0] c, logic fe, logic bk);
    rx_push = 1'b1; rx_char = c; rx_ferr = fe; rx_brk = bk;
    @(negedge clk);
    rx_push = 1'b0; rx_ferr = 1'b0; rx_brk = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  b;
    logic [31:0] rxq[$];
    logic [7:0]  txq[$];
    int unsigned r;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_LVL, d);  chk("R1 level", d, 0);
    rd(A_STAT, d); chk("R1 status", d, 0);
    rd(A_CTRL, d); chk("R1 ctrl", d, 0);
    rd(A_RATE, d); chk("R1 rate", d, 32'hFF);
    chk("R1 irq/brk/avail", {29'h0, irq, line_break, tx_avail}, 0);

    // R12 rate and break
    wr(A_RATE, 32'h2A);
    rd(A_RATE, d); chk("R12 rate read", d, 32'h2A);
    chk("R12 rate_div", 32'(rate_div), 32'h2A);
    wr(A_CTRL, 32'h100);
    chk("R12 line_break on", 32'(line_break), 1);
    wr(A_CTRL, 32'h0);
    chk("R12 line_break off", 32'(line_break), 0);

    // R2 / R5 queue three bytes
    wr(A_DATA, 32'h11); wr(A_DATA, 32'h22); wr(A_DATA, 32'h33);
    rd(A_LVL, d); chk("R5 tx level", d, exp_lvl(3, 0));
    chk("R2 tx_avail", 32'(tx_avail), 1);
    // R8 mark 0
    txp(b); chk("R2 order 0", 32'(b), 32'h11);
    txp(b); chk("R2 order 1", 32'(b), 32'h22);
    rd(A_STAT, d); chk("R8 no req above mark", d & 1, 0);
    txp(b); chk("R2 order 2", 32'(b), 32'h33);
    rd(A_STAT, d); chk("R8 req at empty", d & 1, 1);
    chk("R2 tx_avail clear", 32'(tx_avail), 0);
    wr(A_STAT, 32'h1);
    rd(A_STAT, d); chk("R7 tx W1C", d & 1, 0);

    // R8 mark 4
    wr(A_CTRL, 32'h1);
    for (int i = 0; i < 6; i++) wr(A_DATA, 32'(i));
    txp(b);
    rd(A_STAT, d); chk("R8 count5 no req", d & 1, 0);
    txp(b);
    rd(A_STAT, d); chk("R8 count4 req", d & 1, 1);
    for (int i = 0; i < 4; i++) txp(b);
    wr(A_STAT, 32'h1);
    wr(A_CTRL, 32'h0);

    // R3 overfill transmit
    for (int i = 0; i < 70; i++) wr(A_DATA, 32'(i + 100));
    rd(A_LVL, d); chk("R3 tx capped", d, exp_lvl(DEPTH, 0));
    for (int i = 0; i < DEPTH; i++) begin
      txp(b); chk("R3 kept byte", 32'(b), 32'(i + 100));
    end
    chk("R3 drained", 32'(tx_avail), 0);
    wr(A_STAT, 32'h3F);

    // R4 / R7 receive flags
    rxp(8'h55, 1'b0, 1'b0);
    rxp(8'hA3, 1'b1, 1'b0);
    rxp(8'h00, 1'b0, 1'b1);
    rd(A_STAT, d); chk("R7 fe and brk set", d & 32'h18, 32'h18);
    rd(A_DATA, d); chk("R4 normal char", d, 32'h055);
    rd(A_DATA, d); chk("R4 framing char", d, 32'h2A3);
    rd(A_DATA, d); chk("R4 break char", d, 32'h400);
    rd(A_DATA, d); chk("R4 empty read", d, 32'h100);
    rd(A_LVL, d);  chk("R4 empty pops nothing", d, 0);
    wr(A_STAT, 32'h18);
    rd(A_STAT, d); chk("R7 W1C fe brk", d, 0);

    // R10 timeout, and R7 live bits ignore writes
    rxp(8'h7E, 1'b0, 1'b0);
    repeat (TMO - 2) @(negedge clk);
    rd(A_STAT, d); chk("R10 not yet", d & 4, 0);
    repeat (4) @(negedge clk);
    rd(A_STAT, d); chk("R10 timeout live", d & 4, 4);
    wr(A_STAT, 32'h06);
    rd(A_STAT, d); chk("R7 live bits kept", d & 6, 6);
    rd(A_DATA, d); chk("R10 char", d, 32'h07E);
    rd(A_STAT, d); chk("R10 cleared by empty", d & 6, 0);

    // R6 overrun
    for (int i = 0; i < DEPTH + 1; i++) rxp(8'(i), 1'b0, 1'b0);
    rd(A_STAT, d); chk("R6 overrun set", d & 32'h20, 32'h20);
    rd(A_LVL, d);  chk("R6 rx capped", d, exp_lvl(0, DEPTH));
    for (int i = 0; i < DEPTH; i++) begin
      rd(A_DATA, d); chk("R6 kept char", d, exp_rx(8'(i), 1'b0, 1'b0));
    end
    rd(A_DATA, d); chk("R6 dropped char", d, 32'h100);
    wr(A_STAT, 32'h20);
    rd(A_STAT, d); chk("R7 W1C overrun", d, 0);

    // R9 trigger level 8
    wr(A_CTRL, 32'h08);
    for (int i = 0; i < 7; i++) rxp(8'(i), 1'b0, 1'b0);
    rd(A_STAT, d); chk("R9 below level", d & 2, 0);
    rxp(8'h07, 1'b0, 1'b0);
    rd(A_STAT, d); chk("R9 at level", d & 2, 2);
    rd(A_DATA, d);
    rd(A_STAT, d); chk("R9 dropped below", d & 2, 0);
    for (int i = 0; i < 7; i++) rd(A_DATA, d);
    wr(A_CTRL, 32'h0);

    // R11 interrupt gating
    rxp(8'h01, 1'b1, 1'b0);
    chk("R11 err disabled", 32'(irq), 0);
    wr(A_CTRL, 32'h80);
    chk("R11 err enabled", 32'(irq), 1);
    wr(A_CTRL, 32'h40);
    chk("R11 rx trigger enabled", 32'(irq), 1);
    rd(A_DATA, d);
    chk("R11 rx empty", 32'(irq), 0);
    wr(A_STAT, 32'h3F);
    wr(A_CTRL, 32'h20);
    wr(A_DATA, 32'h5A);
    chk("R11 tx no req yet", 32'(irq), 0);
    txp(b);
    rd(A_STAT, d); chk("R11 set indicator", d & 32'h41, 32'h41);
    chk("R11 tx irq", 32'(irq), 1);
    wr(A_STAT, 32'h1);
    chk("R11 tx irq cleared", 32'(irq), 0);
    wr(A_CTRL, 32'h0);

    // Random mix against queue models (R2 R3 R4 R5 R6)
    r = $urandom(32'd20240611);
    for (int n = 0; n < 600; n++) begin
      r = $urandom % 4;
      case (r)
        0: begin
          logic [7:0] v = 8'($urandom);
          wr(A_DATA, 32'(v));
          if (txq.size() < DEPTH) txq.push_back(v);
        end
        1: begin
          txp(b);
          if (txq.size() > 0) begin
            chk("R2 random tx byte", 32'(b), 32'(txq[0]));
            void'(txq.pop_front());
          end
        end
        2: begin
          logic [7:0] v = 8'($urandom);
          logic fe = 1'($urandom);
          logic bk = 1'($urandom);
          rxp(v, fe, bk);
          if (rxq.size() < DEPTH) rxq.push_back(exp_rx(v, fe, bk));
        end
        default: begin
          rd(A_DATA, d);
          if (rxq.size() > 0) begin
            chk("R4 random rx word", d, rxq[0]);
            void'(rxq.pop_front());
          end else chk("R4 random empty", d, 32'h100);
        end
      endcase
      if (n % 20 == 0) begin
        rd(A_LVL, d); chk("R5 random level", d, exp_lvl(txq.size(), rxq.size()));
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule